// File: doc/BRIEF.md
# Flag-Preserving Result Adjustment Unit

This unit applies a correction to one general register after an arithmetic or shift operation has already produced it. A 4-bit select code picks the correction. The available corrections are:

- decimal fix-up of a packed BCD sum or an excess-3 sum, steered by a saved per-digit carry vector;
- folding the carry flag into the sign bit;
- rounding a signed right-shift quotient toward zero, using the N and V flags;
- adding a small power of two.

The unit reads the saved flags and the digit-carry vector but has no path that writes them. This allows a multi-word decimal sum to reuse one carry vector across several corrections.

An accepted request is registered. Its corrected value appears on the output one clock later and stays there until the next accepted request. Instruction decode and the register file sit outside the block. In the instruction word, bits 7..4 read 0001, bits 15..12 read 0101 and bits 11..8 carry the select code that drives `in_sel`.

Top module: `adj_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_value` is 0.
- R2: A request with `in_valid`=1 makes `out_valid` 1 in the next cycle. In cycles with `in_valid`=0, `out_valid` is 0 one cycle later and `out_value` keeps its previous value.
- R3: Select 0010 (BCD) subtracts 6 modulo 16 from every nibble i (bits 4i+3..4i) whose bit i of `in_dcarry` is 0, and leaves every nibble whose bit is 1 unchanged.
- R4: Select 0011 (excess-3) adds 3 modulo 16 to every nibble i whose bit i of `in_dcarry` is 1, and subtracts 3 modulo 16 from every nibble whose bit is 0.
- R5: Select 0100 adds `in_c` at bit 31. The result wraps modulo 2^32, and bits 30..0 are unchanged.
- R6: Select 0101 adds (`in_n` AND `in_v`) at bit 0, modulo 2^32.
- R7: Selects 1000 through 1111 add 2^k modulo 2^32, where k is the select's low three bits (1, 2, 4 ... 128).
- R8: Reserved selects 0000, 0001, 0110 and 0111 return the register value unchanged.
- R9: The decimal corrections never carry or borrow between nibbles. An all-zero value corrected with BCD select and carry vector 0 gives 0xAAAAAAAA.
- R10: The flags have no effect on power-of-two and reserved selects, and `in_dcarry` has no effect on any non-decimal select.
- R11: An 8-digit BCD add performs three steps: add 0x66666666 to one operand, add the second operand with the nibble carries recorded, then apply BCD select. The result equals the decimal sum modulo 10^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_value | input | 32 | Register value to correct |
| in_sel | input | 4 | Adjustment select code |
| in_dcarry | input | 8 | Saved per-nibble decimal carry vector |
| in_n | input | 1 | Saved negative flag |
| in_v | input | 1 | Saved overflow flag |
| in_c | input | 1 | Saved carry flag |
| out_valid | output | 1 | Corrected value present this cycle |
| out_value | output | 32 | Corrected register value |

## Verification
The bound checker watches every cycle for the following properties:
- the one-cycle latency and the output hold on idle cycles;
- the exact power-of-two increment;
- the identity result of reserved selects, of SSQ when N and V are not both set, and of BCD with an all-ones carry vector;
- the untouched low bits under CMSB.

Per-nibble decimal arithmetic, wraparound and the end-to-end decimal addition against a digit-by-digit reference are shown only by the bench's vector table and its randomized BCD loop.

// File: rtl/adj_pkg.sv
package adj_pkg;

    typedef enum logic [3:0] {
        SEL_RSV0 = 4'b0000,
        SEL_RSV1 = 4'b0001,
        SEL_BCD  = 4'b0010,
        SEL_EX3  = 4'b0011,
        SEL_CMSB = 4'b0100,
        SEL_SSQ  = 4'b0101,
        SEL_RSV6 = 4'b0110,
        SEL_RSV7 = 4'b0111,
        SEL_P1   = 4'b1000,
        SEL_P2   = 4'b1001,
        SEL_P4   = 4'b1010,
        SEL_P8   = 4'b1011,
        SEL_P16  = 4'b1100,
        SEL_P32  = 4'b1101,
        SEL_P64  = 4'b1110,
        SEL_P128 = 4'b1111
    } adj_sel_e;

    // result source chosen by the select code
    typedef enum logic [1:0] {
        SRC_PASS  = 2'd0,
        SRC_DIGIT = 2'd1,
        SRC_ADD   = 2'd2
    } adj_src_e;

    function automatic adj_src_e sel_to_src(input logic [3:0] sel);
        adj_src_e s;
        if (sel[3])
            s = SRC_ADD;
        else if (sel == SEL_CMSB || sel == SEL_SSQ)
            s = SRC_ADD;
        else if (sel == SEL_BCD || sel == SEL_EX3)
            s = SRC_DIGIT;
        else
            s = SRC_PASS;
        return s;
    endfunction

endpackage

// File: rtl/adj_digit_fix.sv
// Per-nibble decimal correction, no inter-nibble carry (R3, R4, R9)
module adj_digit_fix #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NIB_W  = 4,
    localparam int unsigned DIGITS = DATA_W / NIB_W
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [DIGITS-1:0] dcarry_i,
    input  logic              ex3_i,
    output logic [DATA_W-1:0] value_o
);
    localparam logic [NIB_W-1:0] SIX   = NIB_W'(6);
    localparam logic [NIB_W-1:0] THREE = NIB_W'(3);

    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        logic [NIB_W-1:0] nib_in;
        logic [NIB_W-1:0] nib_out;
        assign nib_in = value_i[g*NIB_W +: NIB_W];
        always_comb begin
            if (ex3_i)
                nib_out = dcarry_i[g] ? nib_in + THREE : nib_in - THREE;
            else
                nib_out = dcarry_i[g] ? nib_in : nib_in - SIX;
        end
        assign value_o[g*NIB_W +: NIB_W] = nib_out;
    end
endmodule

// File: rtl/adj_addend.sv
// Addend for flag-driven and power-of-two selects (R5, R6, R7)
module adj_addend #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]        sel_i,
    input  logic              n_i,
    input  logic              v_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] addend_o
);
    import adj_pkg::*;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        addend_o = '0;
        if (sel_i[3])
            addend_o = ONE << sel_i[2:0];
        else if (sel_i == SEL_CMSB)
            addend_o = {c_i, {(DATA_W-1){1'b0}}};
        else if (sel_i == SEL_SSQ)
            addend_o = DATA_W'(n_i & v_i);
    end
endmodule

// File: rtl/adj_unit.sv
module adj_unit #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NIB_W  = 4,
    localparam int unsigned DIGITS = DATA_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [3:0]        in_sel,
    input  logic [DIGITS-1:0] in_dcarry,
    input  logic              in_n,
    input  logic              in_v,
    input  logic              in_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value
);
    import adj_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] val;
    } adj_state_t;

    adj_state_t st_d, st_q;
    logic [DATA_W-1:0] digit_fix;
    logic [DATA_W-1:0] addend;

    adj_digit_fix #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_digit (
        .value_i  (in_value),
        .dcarry_i (in_dcarry),
        .ex3_i    (in_sel == SEL_EX3),
        .value_o  (digit_fix)
    );

    adj_addend #(.DATA_W(DATA_W)) u_addend (
        .sel_i    (in_sel),
        .n_i      (in_n),
        .v_i      (in_v),
        .c_i      (in_c),
        .addend_o (addend)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (sel_to_src(in_sel))
                SRC_DIGIT: st_d.val = digit_fix;
                SRC_ADD:   st_d.val = in_value + addend;
                default:   st_d.val = in_value;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_value = st_q.val;
endmodule

// File: rtl/adj_unit_chk.sv
module adj_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIGITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_value,
    input logic [3:0]        in_sel,
    input logic [DIGITS-1:0] in_dcarry,
    input logic              in_n,
    input logic              in_v,
    input logic              in_c,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_value
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst_seen | !rst_n;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        !in_valid |=> (!out_valid && $stable(out_value)));

    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (in_valid && in_sel[3] == 1'b0 && (in_sel[2:1] == 2'b00 || in_sel[2:1] == 2'b11))
        |=> out_value == $past(in_value));

    p_cmsb_low_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (in_valid && in_sel == 4'b0100)
        |=> out_value[DATA_W-2:0] == $past(in_value[DATA_W-2:0]));

    p_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (in_valid && in_sel[3])
        |=> (out_value - $past(in_value)) == (DATA_W'(1) << $past(in_sel[2:0])));

    p_ssq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (in_valid && in_sel == 4'b0101 && !(in_n && in_v))
        |=> out_value == $past(in_value));

    p_bcd_allcarry_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (in_valid && in_sel == 4'b0010 && &in_dcarry)
        |=> out_value == $past(in_value));
endmodule

bind adj_unit adj_unit_chk #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_value  (in_value),
    .in_sel    (in_sel),
    .in_dcarry (in_dcarry),
    .in_n      (in_n),
    .in_v      (in_v),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_value (out_value)
);

// File: tb/sim_adj_unit.sv
`timescale 1ns/1ps
module sim_adj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [3:0]  in_sel = '0;
    logic [7:0]  in_dcarry = '0;
    logic        in_n = 1'b0, in_v = 1'b0, in_c = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    adj_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_sel(in_sel), .in_dcarry(in_dcarry), .in_n(in_n), .in_v(in_v),
        .in_c(in_c), .out_valid(out_valid), .out_value(out_value)
    );

    // {sel, dcarry, n v c, value, expected}
    localparam int NV = 19;
    localparam logic [78:0] VEC [NV] = '{
        {4'h2, 8'h00, 3'b000, 32'h66666666, 32'h00000000}, // R3
        {4'h2, 8'hFF, 3'b000, 32'h12345678, 32'h12345678}, // R3
        {4'h2, 8'h0F, 3'b000, 32'hAAAA1234, 32'h44441234}, // R3
        {4'h2, 8'h00, 3'b000, 32'h00000000, 32'hAAAAAAAA}, // R9
        {4'h3, 8'hF0, 3'b000, 32'h11115555, 32'h44442222}, // R4
        {4'h3, 8'h00, 3'b000, 32'h00000001, 32'hDDDDDDDE}, // R9
        {4'h3, 8'hFF, 3'b000, 32'hDDDDDDDD, 32'h00000000}, // R4
        {4'h4, 8'h00, 3'b001, 32'h00000001, 32'h80000001}, // R5
        {4'h4, 8'h00, 3'b001, 32'h80000003, 32'h00000003}, // R5 wrap
        {4'h4, 8'hFF, 3'b110, 32'h00001234, 32'h00001234}, // R5 C=0, R10
        {4'h5, 8'h00, 3'b110, 32'hFFFFFFFE, 32'hFFFFFFFF}, // R6
        {4'h5, 8'h00, 3'b100, 32'h00000005, 32'h00000005}, // R6
        {4'h8, 8'h00, 3'b000, 32'hFFFFFFFF, 32'h00000000}, // R7 wrap
        {4'hF, 8'h00, 3'b000, 32'h00000100, 32'h00000180}, // R7
        {4'hC, 8'hA5, 3'b111, 32'h000000F0, 32'h00000100}, // R7, R10
        {4'h0, 8'h00, 3'b111, 32'hDEADBEEF, 32'hDEADBEEF}, // R8, R10
        {4'h7, 8'h3C, 3'b111, 32'hCAFEF00D, 32'hCAFEF00D}, // R8
        {4'h1, 8'h00, 3'b000, 32'h00000000, 32'h00000000}, // R8
        {4'h6, 8'hFF, 3'b101, 32'h76543210, 32'h76543210}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, registered at posedge, sample at next negedge
    task automatic apply(input logic [3:0] s, input logic [7:0] dc,
                         input logic [2:0] nvc, input logic [31:0] v);
        in_sel = s; in_dcarry = dc; {in_n, in_v, in_c} = nvc;
        in_value = v; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 out_value", out_value, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][78:75], VEC[i][74:67], VEC[i][66:64], VEC[i][63:32]);
            check("R2 valid", {31'd0, out_valid}, 32'd1);
            check($sformatf("vector %0d (R3..R10)", i), out_value, VEC[i][31:0]);
        end

        // R2: idle cycle keeps value even with new inputs present
        hold = out_value;
        in_value = 32'h13579BDF; in_sel = 4'h8;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", out_value, hold);

        // R11: end-to-end 8-digit BCD addition
        for (int t = 0; t < 40; t++) begin
            logic [31:0] a, b, x, raw, exp;
            logic [7:0]  dc;
            int ca, cd;
            a = '0; b = '0; exp = '0;
            for (int d = 0; d < 8; d++) begin
                a[d*4 +: 4] = 4'($urandom_range(0, 9));
                b[d*4 +: 4] = 4'($urandom_range(0, 9));
            end
            if (t == 0) begin a = 32'h99999999; b = 32'h00000001; end
            if (t == 1) begin a = 32'h50505050; b = 32'h50505050; end
            x = a + 32'h66666666;
            ca = 0; cd = 0;
            for (int d = 0; d < 8; d++) begin
                int s, ds;
                s = int'(x[d*4 +: 4]) + int'(b[d*4 +: 4]) + ca;
                dc[d] = (s > 15);
                ca = (s > 15) ? 1 : 0;
                ds = int'(a[d*4 +: 4]) + int'(b[d*4 +: 4]) + cd;
                exp[d*4 +: 4] = 4'(ds % 10);
                cd = ds / 10;
            end
            raw = x + b;
            apply(4'h2, dc, 3'b000, raw);
            check($sformatf("R11 bcd add %h+%h", a, b), out_value, exp);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule